// File: doc/BRIEF.md
# Sequential Three-Tap FIR Filter

This block is a three-tap finite impulse response filter. For each accepted input sample x(n) it produces y(n) = C0·x(n) + C1·x(n-1) + C2·x(n-2). The three coefficients are fixed at elaboration through parameters. All arithmetic is unsigned, and the 48-bit sum wraps modulo 2^48.

A single multiplier and accumulator are shared by all three taps. A small controller steps each sample through a fixed sequence: idle, capture, three multiply-accumulate steps, and a final step that publishes the result and advances the two-deep history. The delay line moves only after the result is formed.

A producer raises `in_valid` with a sample while the block is idle. It then waits for the one-cycle `out_ready` pulse, which marks a new `result`. A new sample may be offered in the very cycle that the pulse is high.

Top module: `fir3_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `result` to 0 and `out_ready` to 0, returns the block to idle and empties the sample history. After reset, the previous samples x(n-1) and x(n-2) count as 0.
- R2: While idle, a clock edge with `in_valid` high captures `sample` and starts processing. While `in_valid` stays low, no result is produced and `out_ready` stays 0.
- R3: The published `result` equals C0·x(n) + C1·x(n-1) + C2·x(n-2). Here x(n-1) and x(n-2) are the two samples accepted before x(n) since the last reset.
- R4: `out_ready` is 1 during exactly one cycle. That cycle follows the fifth clock edge after the accepting edge, and it is the cycle in which `result` first shows the new value.
- R5: `out_ready` is 0 in every cycle between the accepting edge and the publishing edge.
- R6: `in_valid` and `sample` are ignored from the accepting edge through the publishing edge. Samples offered then affect neither the current result nor any later result.
- R7: `result` holds its value in every cycle except the one following the publishing edge.
- R8: All products and sums are unsigned. The sum of the three 48-bit products wraps modulo 2^48.
- R9: A sample offered in the cycle where `out_ready` is high is accepted at the next edge. Samples can therefore be taken every six cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample offered this cycle |
| sample | input | 24 | Unsigned input sample |
| result | output | 48 | Filter output, modulo 2^48 |
| out_ready | output | 1 | One-cycle pulse: `result` is new |

## Verification
All-ones samples with near-maximal coefficients drive the accumulator past 2^48. This separates correct modular wrap from a truncated or widened sum. Random samples, both back to back and with idle gaps, tell apart a correct tap-to-coefficient pairing and delay-line order from a swapped one. Other patterns keep `in_valid` high with junk data throughout processing, or assert reset in the middle of a sample. These show whether the busy interval truly ignores the input, and whether reset empties the history, so that the next result contains only the C0 term.

// File: rtl/fir3_seq.sv
module fir3_seq #(
  parameter int W_IN = 24,
  parameter logic [W_IN-1:0] C0 = 24'h000123,
  parameter logic [W_IN-1:0] C1 = 24'h000456,
  parameter logic [W_IN-1:0] C2 = 24'h000789
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [W_IN-1:0]      sample,
  output logic [2*W_IN-1:0]    result,
  output logic                 out_ready
);
  localparam int W_OUT = 2 * W_IN;

  typedef enum logic [2:0] {S_WAIT, S_LOAD, S_CALC1, S_CALC2, S_CALC3, S_SHIFT} state_t;

  state_t            state;
  logic [W_IN-1:0]   rin, rs0, rs1, op, cf;
  logic [W_OUT-1:0]  acc, prod;

  always_comb begin
    case (state)
      S_CALC2: begin op = rs0; cf = C1; end
      S_CALC3: begin op = rs1; cf = C2; end
      default: begin op = rin; cf = C0; end
    endcase
  end

  assign prod = W_OUT'(op) * W_OUT'(cf);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_WAIT;
      rin       <= '0;
      rs0       <= '0;
      rs1       <= '0;
      acc       <= '0;
      result    <= '0;
      out_ready <= 1'b0;
    end else begin
      out_ready <= 1'b0;
      case (state)
        S_WAIT:  if (in_valid) begin rin <= sample; state <= S_LOAD; end
        S_LOAD:  state <= S_CALC1;
        S_CALC1: begin acc <= prod;       state <= S_CALC2; end
        S_CALC2: begin acc <= acc + prod; state <= S_CALC3; end
        S_CALC3: begin acc <= acc + prod; state <= S_SHIFT; end
        S_SHIFT: begin
          result    <= acc;
          rs1       <= rs0;
          rs0       <= rin;
          out_ready <= 1'b1;
          state     <= S_WAIT;
        end
        default: state <= S_WAIT;
      endcase
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (result == '0 && !out_ready && rs0 == '0 && rs1 == '0)); // R1
  AST_ACCEPT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (state == S_WAIT && in_valid) |=> (state == S_LOAD && rin == $past(sample))); // R2
  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (rst) out_ready |=> !out_ready); // R4
  AST_READY_CARRIES_ACC: assert property (@(posedge clk) disable iff (rst)
    (state == S_SHIFT) |=> (out_ready && result == $past(acc))); // R4
  AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (rst)
    (state == S_LOAD || state == S_CALC1 || state == S_CALC2 || state == S_CALC3) |-> !out_ready); // R5
  AST_BUSY_KEEPS_RIN: assert property (@(posedge clk) disable iff (rst)
    (state != S_WAIT) |=> $stable(rin)); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state != S_SHIFT) |=> $stable(result)); // R7
  AST_DELAY_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (state == S_SHIFT) |=> (rs1 == $past(rs0) && rs0 == $past(rin))); // R3
endmodule

// File: tb/tb_fir3_seq.sv
module tb_fir3_seq;
  localparam logic [23:0] K0 = 24'hFFFFFF;
  localparam logic [23:0] K1 = 24'hABCDEF;
  localparam logic [23:0] K2 = 24'h800001;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [23:0] sample = '0;
  logic [47:0] result;
  logic        out_ready;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [23:0] h1 = '0, h2 = '0;
  logic [47:0] last = '0;

  fir3_seq #(.W_IN(24), .C0(K0), .C1(K1), .C2(K2)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .sample(sample),
    .result(result), .out_ready(out_ready));

  always #4 clk = ~clk;

  function automatic logic [47:0] model(logic [23:0] x, logic [23:0] a, logic [23:0] b);
    return 48'(x) * 48'(K0) + 48'(a) * 48'(K1) + 48'(b) * 48'(K2);
  endfunction

  task automatic chk(bit ok, string tag, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      chk(out_ready == 1'b0, "R2 no pulse while idle", 48'(out_ready), 48'd0);
      chk(result == last, "R7 result held", result, last);
    end
  endtask

  task automatic run(logic [23:0] x, bit noisy);
    logic [47:0] exp;
    in_valid = 1'b1;
    sample   = x;
    @(posedge clk);
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      in_valid = noisy;
      sample   = 24'($urandom);
      chk(out_ready == 1'b0, "R5 busy low", 48'(out_ready), 48'd0);
      chk(result == last, "R7 hold while busy", result, last);
    end
    @(negedge clk);
    in_valid = 1'b0;
    exp = model(x, h1, h2);
    chk(out_ready == 1'b1, "R4 pulse after fifth edge", 48'(out_ready), 48'd1);
    chk(result == exp, noisy ? "R6 R3 result with busy junk" : "R3 R9 result", result, exp);
    h2 = h1;
    h1 = x;
    last = exp;
  endtask

  initial begin
    void'($urandom(32'd2024));
    in_valid = 1'b1;
    sample = 24'hFFFFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(result == 48'd0, "R1 reset result", result, 48'd0);
    chk(out_ready == 1'b0, "R1 reset ready", 48'(out_ready), 48'd0);
    rst = 1'b0;
    in_valid = 1'b0;
    idle(4);

    run(24'hFFFFFF, 1'b0);
    run(24'hFFFFFF, 1'b0);
    run(24'hFFFFFF, 1'b0);
    chk(last == model(24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF), "R8 wrap modulo 2^48",
        last, model(24'hFFFFFF, 24'hFFFFFF, 24'hFFFFFF));
    idle(1);
    run(24'h000001, 1'b1);
    run(24'h000000, 1'b0);
    run(24'h000000, 1'b1);
    idle(2);

    for (int i = 0; i < 40; i++) begin
      run(24'($urandom), 1'($urandom));
      if ($urandom_range(0, 2) == 0) idle($urandom_range(1, 3));
    end

    in_valid = 1'b1;
    sample = 24'h123456;
    @(posedge clk);
    @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    chk(result == 48'd0, "R1 mid reset result", result, 48'd0);
    chk(out_ready == 1'b0, "R1 mid reset ready", 48'(out_ready), 48'd0);
    rst = 1'b0;
    h1 = '0;
    h2 = '0;
    last = '0;
    idle(3);
    run(24'h00ABCD, 1'b0);
    chk(last == 48'(24'h00ABCD) * 48'(K0), "R1 history emptied", last, 48'(24'h00ABCD) * 48'(K0));
    idle(2);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule